// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Pin Interrupts

This block holds a set of 8-bit general-purpose I/O ports behind a small synchronous register bus. Each port keeps an output value and a direction mask that drive the pad-side `pin_out` and `pin_oe` buses. Reading a port's data register returns the stored value for pins set as outputs and the synchronized pad level for pins set as inputs.

Three of the ports also carry per-pin interrupt logic. For each pin, software picks edge or level detection, picks the active direction (rising/high or falling/low), turns on an optional debounce filter and sets an enable bit. Edge events are caught in a status latch that stays set until software writes a one to the matching bit of a write-one acknowledge register. Two of these ports feed one shared interrupt line. The third port drives one interrupt line per pin. Pad inputs pass through a two-flop synchronizer. The debounce filter accepts a change only after it has held for a set number of cycles.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: `pin_out` slice of port p equals port p's data register (offset 0). A bus write is visible on the slice in the cycle after the write. Without a write to it, the slice does not change.
- R2: A direction bit (offset 1) of 1 drives the matching `pin_oe` bit high, so the pin is an output. A direction bit of 0 makes the pin an input. A write is visible the cycle after.
- R3: A read (bus_sel=1, bus_wr=0) puts data on `bus_rdata` in the next cycle, and `bus_rdata` holds between reads. A data-register read returns the stored bit for output pins. For input pins it returns the pad level delayed by two clocks.
- R4: The address is {port index, 4-bit offset}. The interrupt offsets are: 2 enable, 3 edge select, 4 polarity, 5 acknowledge, 6 debounce enable, 7 raw status and 8 masked status. On ports without interrupt logic, these offsets read 0 and writes to them are ignored.
- R5: After reset, every register is 0, all interrupt enables are clear and both interrupt outputs are low.
- R6: In edge mode (edge bit 1), a filtered transition toward the polarity level (1 = rising, 0 = falling) sets the pin's latch, but only while its enable bit is 1. The latch holds until a 1 is written to that pin's acknowledge bit. The acknowledge offset reads 0.
- R7: In level mode (edge bit 0), the pin's raw status is 1 while its filtered level equals its polarity bit. The interrupt follows that level with no latching.
- R8: A pin with enable 0 sets no latch and never drives an interrupt output. Its raw status still shows its level-mode state.
- R9: `irq_shared` is high when any pin of port 0 or port 1 has masked status 1. `irq_pin[i]` is the masked status of pin i of port 5.
- R10: With its debounce bit 1, a pin's filtered level follows the synchronized level only after the two have differed for DEB_CYC consecutive cycles, so shorter pulses are dropped. With debounce off, the filtered level follows one cycle after synchronization.
- R11: Offset 7 returns the raw status (latch in edge mode, level match in level mode). Offset 8 returns raw status ANDed with the enables.
- R12: If an acknowledge write and a new edge event hit the same pin in the same cycle, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(NUM_PORTS)+4 | {port index, register offset} |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data, valid the cycle after a read |
| pin_in | input | NUM_PORTS*PIN_W | Pad input levels, port p at bits p*PIN_W upward |
| pin_out | output | NUM_PORTS*PIN_W | Pad output values |
| pin_oe | output | NUM_PORTS*PIN_W | Pad output enables |
| irq_shared | output | 1 | Combined interrupt of ports 0 and 1 |
| irq_pin | output | PIN_W | Per-pin interrupts of port 5 |

## Verification
The bench builds the block with 8 ports of 8 pins and DEB_CYC lowered to 3. This keeps debounce windows short, so both a dropped 2-cycle pulse and an accepted 6-cycle pulse fit in a few cycles. The default port-to-interrupt mapping is kept, so the shared line, the per-pin lines and the ports without interrupt logic are all exercised. The bench also lines up an acknowledge write with a new edge in the exact cycle that edge is detected, which reaches the tie case where the edge must win.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_SEL_W = 4;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_DATA = 4'd0,
    REG_DIR  = 4'd1,
    REG_IEN  = 4'd2,
    REG_EDGE = 4'd3,
    REG_POL  = 4'd4,
    REG_ACK  = 4'd5,
    REG_DBEN = 4'd6,
    REG_RAW  = 4'd7,
    REG_MASK = 4'd8
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync_filter.sv
module gpio_sync_filter #(
  parameter int unsigned PIN_W   = 8,
  parameter int unsigned DEB_CYC = 4,
  parameter bit          HAS_DEB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_raw,
  input  logic [PIN_W-1:0] db_en,
  output logic [PIN_W-1:0] sync_q,
  output logic [PIN_W-1:0] filt_q,
  output logic [PIN_W-1:0] filt_chg
);
  localparam int unsigned CNT_W = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

  logic [PIN_W-1:0] meta_q, meta_d, s2_d;

  always_comb begin
    meta_d = pin_raw;
    s2_d   = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= s2_d;
    end
  end

  generate
    if (HAS_DEB) begin : g_deb
      for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        logic [CNT_W-1:0] cnt_q, cnt_d;
        logic             f_q, f_d;

        always_comb begin
          f_d   = f_q;
          cnt_d = '0;
          if (!db_en[i]) begin
            f_d = sync_q[i];
          end else if (sync_q[i] != f_q) begin
            if (cnt_q == CNT_LAST) f_d = sync_q[i];
            else                   cnt_d = cnt_q + 1'b1;
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            f_q   <= 1'b0;
            cnt_q <= '0;
          end else begin
            f_q   <= f_d;
            cnt_q <= cnt_d;
          end
        end

        assign filt_q[i]   = f_q;
        assign filt_chg[i] = f_d ^ f_q;
      end
    end else begin : g_nodeb
      assign filt_q   = sync_q;
      assign filt_chg = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  reg_sel_e         reg_sel,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] filt,
  input  logic [PIN_W-1:0] filt_chg,
  output logic [PIN_W-1:0] ien_q,
  output logic [PIN_W-1:0] edge_q,
  output logic [PIN_W-1:0] pol_q,
  output logic [PIN_W-1:0] dben_q,
  output logic [PIN_W-1:0] raw,
  output logic [PIN_W-1:0] masked
);
  logic             we_ien, we_edge, we_pol, we_dben;
  logic [PIN_W-1:0] ack_vec, hit, lvl_match;
  logic [PIN_W-1:0] latch_q, latch_d;

  always_comb begin
    we_ien  = wr_stb && (reg_sel == REG_IEN);
    we_edge = wr_stb && (reg_sel == REG_EDGE);
    we_pol  = wr_stb && (reg_sel == REG_POL);
    we_dben = wr_stb && (reg_sel == REG_DBEN);
    ack_vec = (wr_stb && (reg_sel == REG_ACK)) ? wdata : '0;
    // transition toward the polarity level, edge mode, enabled
    hit       = filt_chg & (filt ^ pol_q) & edge_q & ien_q;
    latch_d   = (latch_q & ~ack_vec) | hit;
    lvl_match = ~(filt ^ pol_q);
    raw       = (edge_q & latch_q) | (~edge_q & lvl_match);
    masked    = raw & ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      edge_q  <= '0;
      pol_q   <= '0;
      dben_q  <= '0;
      latch_q <= '0;
    end else begin
      if (we_ien)  ien_q  <= wdata;
      if (we_edge) edge_q <= wdata;
      if (we_pol)  pol_q  <= wdata;
      if (we_dben) dben_q <= wdata;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_W   = 8,
  parameter int unsigned DEB_CYC = 4,
  parameter bit          HAS_IRQ = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  reg_sel_e         reg_sel,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_raw,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe,
  output logic [PIN_W-1:0] rd_val,
  output logic [PIN_W-1:0] irq_vec
);
  logic [PIN_W-1:0] data_q, dir_q;
  logic             we_data, we_dir;
  logic [PIN_W-1:0] sync_v, filt_v, chg_v, db_v;
  logic [PIN_W-1:0] irq_rd;

  assign we_data = wr_stb && (reg_sel == REG_DATA);
  assign we_dir  = wr_stb && (reg_sel == REG_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (we_data) data_q <= wdata;
      if (we_dir)  dir_q  <= wdata;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  gpio_sync_filter #(
    .PIN_W  (PIN_W),
    .DEB_CYC(DEB_CYC),
    .HAS_DEB(HAS_IRQ)
  ) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_raw),
    .db_en   (db_v),
    .sync_q  (sync_v),
    .filt_q  (filt_v),
    .filt_chg(chg_v)
  );

  generate
    if (HAS_IRQ) begin : g_irq
      logic [PIN_W-1:0] ien_v, edge_v, pol_v, raw_v, mask_v;

      gpio_irq_bank #(.PIN_W(PIN_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .filt    (filt_v),
        .filt_chg(chg_v),
        .ien_q   (ien_v),
        .edge_q  (edge_v),
        .pol_q   (pol_v),
        .dben_q  (db_v),
        .raw     (raw_v),
        .masked  (mask_v)
      );

      assign irq_vec = mask_v;

      always_comb begin
        unique case (reg_sel)
          REG_IEN:  irq_rd = ien_v;
          REG_EDGE: irq_rd = edge_v;
          REG_POL:  irq_rd = pol_v;
          REG_DBEN: irq_rd = db_v;
          REG_RAW:  irq_rd = raw_v;
          REG_MASK: irq_rd = mask_v;
          default:  irq_rd = '0;
        endcase
      end
    end else begin : g_noirq
      assign db_v    = '0;
      assign irq_vec = '0;
      assign irq_rd  = '0;
    end
  endgenerate

  always_comb begin
    unique case (reg_sel)
      REG_DATA: rd_val = (dir_q & data_q) | (~dir_q & sync_v);
      REG_DIR:  rd_val = dir_q;
      default:  rd_val = irq_rd;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS    = 8,
  parameter int unsigned PIN_W        = 8,
  parameter int unsigned DEB_CYC      = 4,
  parameter int unsigned SHARED_PORT0 = 0,
  parameter int unsigned SHARED_PORT1 = 1,
  parameter int unsigned SPLIT_PORT   = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [$clog2(NUM_PORTS)+3:0]    bus_addr,
  input  logic [PIN_W-1:0]                bus_wdata,
  output logic [PIN_W-1:0]                bus_rdata,
  input  logic [NUM_PORTS*PIN_W-1:0]      pin_in,
  output logic [NUM_PORTS*PIN_W-1:0]      pin_out,
  output logic [NUM_PORTS*PIN_W-1:0]      pin_oe,
  output logic                            irq_shared,
  output logic [PIN_W-1:0]                irq_pin
);
  localparam int unsigned PORT_IDX_W = $clog2(NUM_PORTS);
  localparam int unsigned ADDR_W     = PORT_IDX_W + REG_SEL_W;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [PORT_IDX_W-1:0]               port_idx;
  reg_sel_e                            reg_sel;
  logic [NUM_PORTS-1:0]                wr_stb;
  logic [NUM_PORTS-1:0][PIN_W-1:0]     rd_val;
  logic [NUM_PORTS-1:0][PIN_W-1:0]     irq_vec;
  logic                                rd_en;
  logic [PIN_W-1:0]                    rd_mux;

  assign port_idx = bus_addr[ADDR_W-1:REG_SEL_W];
  assign reg_sel  = reg_sel_e'(bus_addr[REG_SEL_W-1:0]);
  assign rd_en    = bus_sel && !bus_wr;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam bit IRQ_CAP = (p == SHARED_PORT0) || (p == SHARED_PORT1) || (p == SPLIT_PORT);

      assign wr_stb[p] = bus_sel && bus_wr && (port_idx == PORT_IDX_W'(p));

      gpio_port #(
        .PIN_W  (PIN_W),
        .DEB_CYC(DEB_CYC),
        .HAS_IRQ(IRQ_CAP)
      ) u_port (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .wr_stb (wr_stb[p]),
        .reg_sel(reg_sel),
        .wdata  (bus_wdata),
        .pin_raw(pin_in[p*PIN_W +: PIN_W]),
        .pin_out(pin_out[p*PIN_W +: PIN_W]),
        .pin_oe (pin_oe[p*PIN_W +: PIN_W]),
        .rd_val (rd_val[p]),
        .irq_vec(irq_vec[p])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_idx == PORT_IDX_W'(p)) rd_mux = rd_val[p];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else if (rd_en)  bus_rdata <= rd_mux;
  end

  assign irq_shared = (|irq_vec[SHARED_PORT0]) | (|irq_vec[SHARED_PORT1]);
  assign irq_pin    = irq_vec[SPLIT_PORT];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NUM_PORTS    = 8,
  parameter int unsigned PIN_W        = 8,
  parameter int unsigned SHARED_PORT0 = 0,
  parameter int unsigned SHARED_PORT1 = 1,
  parameter int unsigned SPLIT_PORT   = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_wr,
  input logic [$clog2(NUM_PORTS)+3:0] bus_addr,
  input logic [PIN_W-1:0]             bus_wdata,
  input logic [PIN_W-1:0]             bus_rdata,
  input logic [NUM_PORTS*PIN_W-1:0]   pin_out,
  input logic [NUM_PORTS*PIN_W-1:0]   pin_oe
);
  localparam int unsigned PW = $clog2(NUM_PORTS);

  logic [PW-1:0] a_port;
  logic [3:0]    a_reg;
  logic          is_rd, is_wr, a_cap;

  assign a_port = bus_addr[PW+3:4];
  assign a_reg  = bus_addr[3:0];
  assign is_rd  = bus_sel && !bus_wr;
  assign is_wr  = bus_sel && bus_wr;
  assign a_cap  = (a_port == PW'(SHARED_PORT0)) || (a_port == PW'(SHARED_PORT1)) ||
                  (a_port == PW'(SPLIT_PORT));

  // R3: read data only moves on a read
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> $stable(bus_rdata));

  // R4: interrupt offsets of ports without interrupt logic read zero
  p_noirq_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !a_cap && a_reg >= 4'd2 && a_reg <= 4'd8) |=> (bus_rdata == '0));

  // R6: acknowledge offset reads zero
  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && a_reg == 4'd5) |=> (bus_rdata == '0));

  // R1 and R2: pad outputs hold without a write
  p_pads_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !is_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      // R1: data write lands on the pad slice
      p_out_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && a_port == PW'(p) && a_reg == 4'd0)
        |=> (pin_out[p*PIN_W +: PIN_W] == $past(bus_wdata)));
      // R2: direction write lands on the enable slice
      p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && a_port == PW'(p) && a_reg == 4'd1)
        |=> (pin_oe[p*PIN_W +: PIN_W] == $past(bus_wdata)));
    end
  endgenerate
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .PIN_W       (PIN_W),
  .SHARED_PORT0(SHARED_PORT0),
  .SHARED_PORT1(SHARED_PORT1),
  .SPLIT_PORT  (SPLIT_PORT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int NP = 8;
  localparam int PW = 8;
  localparam int DEB = 3;
  localparam int CLK_PERIOD = 10;

  logic            clk, rst_n, bus_sel, bus_wr;
  logic [6:0]      bus_addr;
  logic [PW-1:0]   bus_wdata, bus_rdata, irq_pin;
  logic [NP*PW-1:0] pin_in, pin_out, pin_oe;
  logic            irq_shared;

  int total = 0;
  int bad = 0;
  bit done = 0;

  gpio_irq_ctrl #(.NUM_PORTS(NP), .PIN_W(PW), .DEB_CYC(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_shared(irq_shared), .irq_pin(irq_pin)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_data[NP], m_dir[NP], m_ien[NP], m_edge[NP], m_pol[NP], m_db[NP];
  int m_latch[NP], m_s1[NP], m_s2[NP], m_filt[NP];
  int m_cnt[NP][PW];
  int m_rdata;

  function automatic bit has_irq(int p);
    return (p == 0) || (p == 1) || (p == 5);
  endfunction

  function automatic int m_raw(int p);
    int r = 0;
    for (int b = 0; b < PW; b++) begin
      if ((m_edge[p] >> b) & 1) r |= m_latch[p] & (1 << b);
      else if (((m_filt[p] >> b) & 1) == ((m_pol[p] >> b) & 1)) r |= (1 << b);
    end
    return r;
  endfunction

  function automatic int m_read(int p, int r);
    if (r == 0) return (m_dir[p] & m_data[p]) | (~m_dir[p] & m_s2[p] & 8'hFF);
    if (r == 1) return m_dir[p];
    if (!has_irq(p)) return 0;
    case (r)
      2: return m_ien[p];
      3: return m_edge[p];
      4: return m_pol[p];
      6: return m_db[p];
      7: return m_raw(p);
      8: return m_raw(p) & m_ien[p];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_data[p] = 0; m_dir[p] = 0; m_ien[p] = 0; m_edge[p] = 0; m_pol[p] = 0;
        m_db[p] = 0; m_latch[p] = 0; m_s1[p] = 0; m_s2[p] = 0; m_filt[p] = 0;
        for (int b = 0; b < PW; b++) m_cnt[p][b] = 0;
      end
      m_rdata = 0;
    end else begin
      int pt, rg;
      pt = int'(bus_addr[6:4]);
      rg = int'(bus_addr[3:0]);
      if (bus_sel && !bus_wr) m_rdata = m_read(pt, rg);
      for (int p = 0; p < NP; p++) begin
        if (has_irq(p)) begin
          int nf, ev, ack;
          nf = m_filt[p]; ev = 0;
          ack = (bus_sel && bus_wr && pt == p && rg == 5) ? int'(bus_wdata) : 0;
          for (int b = 0; b < PW; b++) begin
            int sb, fb, nb;
            sb = (m_s2[p] >> b) & 1;
            fb = (m_filt[p] >> b) & 1;
            nb = fb;
            if (!((m_db[p] >> b) & 1)) begin
              nb = sb; m_cnt[p][b] = 0;
            end else if (sb == fb) begin
              m_cnt[p][b] = 0;
            end else if (m_cnt[p][b] == DEB - 1) begin
              nb = sb; m_cnt[p][b] = 0;
            end else begin
              m_cnt[p][b]++;
            end
            if (nb != fb && ((m_edge[p] >> b) & 1) && ((m_ien[p] >> b) & 1) &&
                nb == ((m_pol[p] >> b) & 1)) ev |= (1 << b);
            nf = nb ? (nf | (1 << b)) : (nf & ~(1 << b));
          end
          m_filt[p]  = nf;
          m_latch[p] = (m_latch[p] & ~ack) | ev;
        end
      end
      if (bus_sel && bus_wr) begin
        if (rg == 0) m_data[pt] = int'(bus_wdata);
        if (rg == 1) m_dir[pt] = int'(bus_wdata);
        if (has_irq(pt)) begin
          if (rg == 2) m_ien[pt] = int'(bus_wdata);
          if (rg == 3) m_edge[pt] = int'(bus_wdata);
          if (rg == 4) m_pol[pt] = int'(bus_wdata);
          if (rg == 6) m_db[pt] = int'(bus_wdata);
        end
      end
      for (int p = 0; p < NP; p++) begin
        m_s2[p] = m_s1[p];
        m_s1[p] = int'(pin_in[p*PW +: PW]);
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NP*PW-1:0] e_out, e_oe;
      logic             e_sh;
      for (int p = 0; p < NP; p++) begin
        e_out[p*PW +: PW] = PW'(m_data[p]);
        e_oe[p*PW +: PW]  = PW'(m_dir[p]);
      end
      e_sh = ((m_raw(0) & m_ien[0]) | (m_raw(1) & m_ien[1])) != 0;
      total++;
      if (pin_out !== e_out) begin bad++; $display("FAIL R1 pin_out act=%h exp=%h", pin_out, e_out); end
      else if (pin_oe !== e_oe) begin bad++; $display("FAIL R2 pin_oe act=%h exp=%h", pin_oe, e_oe); end
      else if (bus_rdata !== PW'(m_rdata)) begin bad++; $display("FAIL R3 rdata act=%h exp=%h", bus_rdata, PW'(m_rdata)); end
      else if (irq_shared !== e_sh) begin bad++; $display("FAIL R9 irq_shared act=%b exp=%b", irq_shared, e_sh); end
      else if (irq_pin !== PW'(m_raw(5) & m_ien[5])) begin
        bad++; $display("FAIL R9 irq_pin act=%h exp=%h", irq_pin, PW'(m_raw(5) & m_ien[5]));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int p, int r, int d);
    bus_sel = 1; bus_wr = 1; bus_addr = {3'(p), 4'(r)}; bus_wdata = PW'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int p, int r, int exp, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = {3'(p), 4'(r)};
    @(negedge clk);
    bus_sel = 0;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic setpin(int p, int b, bit v);
    pin_in[p*PW + b] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R5: reset state
    chk("R5 irq_shared", 64'(irq_shared), 0);
    chk("R5 irq_pin", 64'(irq_pin), 0);
    chk("R5 pin_out", 64'(pin_out), 0);
    rd(0, 2, 0, "R5 enable after reset");

    // R1 R2 R3: data, direction, mixed read
    wr(3, 0, 8'hA5);
    wr(3, 1, 8'hF0);
    chk("R1 port3 out", 64'(pin_out[24 +: 8]), 64'hA5);
    chk("R2 port3 oe", 64'(pin_oe[24 +: 8]), 64'hF0);
    pin_in[24 +: 8] = 8'h3C;
    idle(3);
    rd(3, 0, 8'hAC, "R3 mixed data read");

    // R4: interrupt offsets absent on port 3
    wr(3, 2, 8'hFF);
    rd(3, 2, 0, "R4 enable on plain port");
    rd(3, 7, 0, "R4 raw on plain port");

    // R6 R8: rising edge on port5 pins 2,3, only pin 2 enabled
    wr(5, 3, 8'hFF);
    wr(5, 4, 8'hFF);
    wr(5, 2, 8'h04);
    setpin(5, 2, 1); setpin(5, 3, 1);
    idle(4);
    chk("R6 edge latched", 64'(irq_pin), 64'h04);
    rd(5, 7, 8'h04, "R8 disabled pin sets no latch");
    setpin(5, 2, 0); setpin(5, 3, 0);
    idle(4);
    chk("R6 latch holds", 64'(irq_pin), 64'h04);
    rd(5, 5, 0, "R6 ack reads zero");
    wr(5, 5, 8'h04);
    chk("R6 ack clears", 64'(irq_pin), 0);

    // R12: ack in the same cycle as a new edge
    setpin(5, 2, 1);
    idle(2);
    wr(5, 5, 8'h04);
    chk("R12 edge wins over ack", 64'(irq_pin), 64'h04);

    // R7 R8 R11: low-level on port0 pin1
    wr(0, 2, 8'h02);
    chk("R7 low level asserts", 64'(irq_shared), 1);
    setpin(0, 1, 1);
    idle(3);
    chk("R7 level released", 64'(irq_shared), 0);
    rd(0, 7, 8'hFD, "R11 raw status level mode");
    rd(0, 8, 8'h00, "R8 masked status");

    // R9: port1 high level onto shared line
    wr(1, 4, 8'h01);
    wr(1, 2, 8'h01);
    setpin(1, 0, 1);
    idle(4);
    chk("R9 port1 on shared line", 64'(irq_shared), 1);
    chk("R9 split port unaffected", 64'(irq_pin), 64'h04);
    rd(1, 8, 8'h01, "R11 masked status");
    wr(5, 5, 8'hFF);
    chk("R9 per-pin line cleared", 64'(irq_pin), 0);

    // R10: debounce on port5 pin0
    wr(5, 6, 8'h01);
    wr(5, 2, 8'h01);
    setpin(5, 0, 1);
    idle(2);
    setpin(5, 0, 0);
    idle(8);
    chk("R10 short pulse dropped", 64'(irq_pin), 0);
    setpin(5, 0, 1);
    idle(8);
    chk("R10 long pulse accepted", 64'(irq_pin), 64'h01);
    rd(5, 6, 8'h01, "R10 debounce readback");

    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule